// File: doc/BRIEF.md
# Two-Wire Serial Register-Write Receiver

This block accepts register writes from an external master over a slow two-wire link: a serial clock line and a serial data line. The block's much faster system clock oversamples both lines. The block watches for a frame opening and then collects an 8-bit register address followed by a 32-bit value. When it sees a closing condition on a correctly sized frame, it turns the frame into a single-cycle parallel write on a settings bus. The link has no device addressing and no acknowledge slots, so every frame has the same fixed length.

Both lines first pass through a two-flop synchroniser. A small detector then compares each synchronised sample with the previous one to find clock rising edges, openings and closings. A counter and shift register collect the bits and check the length of the frame. A frame of the wrong length is dropped without a trace on the outputs. An opening seen in the middle of a frame throws away the partial frame and starts over.

Top module: `ser_cfg_rx`

## Requirements
- R1: While reset is high and after it is released, the strobe `wr_stb` is 0, `wr_addr` and `wr_data` are 0, and no frame is in progress. Reset is synchronous and active high.
- R2: Both lines idle high. A frame opens when the data line falls while the clock line is high.
- R3: Each bit is taken from the data line at a rising edge of the serial clock. The first 8 bits form the address and the next 32 bits form the data, each most significant bit first.
- R4: A frame closes when the data line rises while the clock line is high. To be valid, the frame must contain exactly 41 serial clock rising edges: 40 payload bits plus the rising edge that sets up the closing, with data low. A valid closing produces a write carrying the captured address and data.
- R5: `wr_stb` is high for exactly one system clock cycle per valid frame. `wr_addr` and `wr_data` change only in a cycle where `wr_stb` is high, and they hold their values otherwise.
- R6: A closing after any other number of rising edges (for example 39 or 41 payload bits) produces no strobe and leaves `wr_addr` and `wr_data` unchanged.
- R7: An opening seen in the middle of a frame clears the bit count. The next 40 bits and closing form a new frame.
- R8: A closing seen while no frame is in progress has no effect. A reset in the middle of a frame discards it, so its later bits and closing produce no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line from the master (asynchronous) |
| sda_in | input | 1 | Serial data line from the master (asynchronous) |
| wr_stb | output | 1 | One-cycle settings write strobe |
| wr_addr | output | 8 | Register address of the last valid write |
| wr_data | output | 32 | Data word of the last valid write |

## Verification
The hardest case to reach from the ports is a frame that is off by exactly one bit. The closing sequence has its own clock rising edge, so frames of 39, 40 and 41 payload bits produce edge counts that differ by one. The stimulus table drives each of these lengths with the same closing waveform and checks that only the 40-bit frame produces a strobe. Restart in the middle of a frame and reset in the middle of a frame are driven as directed sequences. The reset case is applied while the clock line is low, so that releasing reset cannot create a false opening.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RECV = 1'b1
  } rx_state_t;
endpackage

// File: rtl/ser_cfg_sync.sv
module ser_cfg_sync #(
  parameter int WIDTH   = 2,
  parameter int STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= async_in;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign sync_out = pipe[STAGES-1];
endmodule

// File: rtl/ser_cfg_cond.sv
module ser_cfg_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // clock held high across both samples, data moved
  function automatic logic data_edge_under_clk(input logic c_now, c_prev,
                                               d_now, d_prev, rising);
    return c_now && c_prev && (rising ? (!d_prev && d_now) : (d_prev && !d_now));
  endfunction

  assign scl_rise  = scl_s && !scl_q;
  assign start_evt = data_edge_under_clk(scl_s, scl_q, sda_s, sda_q, 1'b0);
  assign stop_evt  = data_edge_under_clk(scl_s, scl_q, sda_s, sda_q, 1'b1);
endmodule

// File: rtl/ser_cfg_shift.sv
module ser_cfg_shift
  import ser_cfg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int FRAME_W = ADDR_W + DATA_W,
  parameter int CNT_W   = $clog2(FRAME_W + 3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              sda_s,
  input  logic              start_evt,
  input  logic              stop_evt,
  output logic              in_frame,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              frame_ok,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  rx_state_t          state;
  logic [FRAME_W-1:0] shreg;

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return (c == CNT_SAT) ? c : c + 1'b1;
  endfunction

  function automatic logic [FRAME_W-1:0] shift_bit(input logic [FRAME_W-1:0] v,
                                                   input logic b);
    return {v[FRAME_W-2:0], b};
  endfunction

  // payload bits plus the clock edge that prepares the stop
  function automatic logic frame_complete(input logic [CNT_W-1:0] c);
    return c == CNT_GOOD;
  endfunction

  assign in_frame = (state == ST_RECV);
  assign frame_ok = frame_complete(bit_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_evt) begin
        state   <= ST_RECV;
        bit_cnt <= '0;
        shreg   <= '0;
      end else if (state == ST_RECV) begin
        if (stop_evt) begin
          state <= ST_IDLE;
          if (frame_ok) begin
            wr_stb  <= 1'b1;
            wr_addr <= shreg[FRAME_W-1 -: ADDR_W];
            wr_data <= shreg[DATA_W-1:0];
          end
        end else if (scl_rise) begin
          bit_cnt <= cnt_step(bit_cnt);
          if (bit_cnt < CNT_FULL) shreg <= shift_bit(shreg, sda_s);
        end
      end
    end
  end
endmodule

// File: rtl/ser_cfg_rx.sv
module ser_cfg_rx #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 3);

  logic [1:0]       lines_s;
  logic             scl_s, sda_s;
  logic             scl_rise, start_evt, stop_evt;
  logic             in_frame, frame_ok;
  logic [CNT_W-1:0] bit_cnt;

  ser_cfg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) sync_i (
    .clk(clk), .rst(rst), .async_in({scl_in, sda_in}), .sync_out(lines_s)
  );

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  ser_cfg_cond cond_i (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  ser_cfg_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W),
                  .CNT_W(CNT_W)) shift_i (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .sda_s(sda_s),
    .start_evt(start_evt), .stop_evt(stop_evt), .in_frame(in_frame),
    .bit_cnt(bit_cnt), .frame_ok(frame_ok), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: rtl/ser_cfg_rx_chk.sv
module ser_cfg_rx_chk #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int FRAME_W = 40,
  parameter int CNT_W   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              in_frame,
  input logic [CNT_W-1:0]  bit_cnt
);
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb); // R5
  AST_STB_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(stop_evt) && $past(in_frame)); // R4
  AST_STB_LENGTH: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(bit_cnt) == CNT_W'(FRAME_W + 1)); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |-> $stable(wr_addr) && $stable(wr_data)); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> in_frame && bit_cnt == '0); // R7
  AST_IDLE_STOP: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && !in_frame && !start_evt) |=> !wr_stb); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !wr_stb && !in_frame); // R1
endmodule

bind ser_cfg_rx ser_cfg_rx_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                                 .FRAME_W(FRAME_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
  .start_evt(start_evt), .stop_evt(stop_evt), .in_frame(in_frame),
  .bit_cnt(bit_cnt)
);

// File: tb/ser_cfg_rx_tb_top.sv
module ser_cfg_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int NVEC       = 8;
  // [47:40] payload bit count, [39:32] address, [31:0] data
  localparam logic [47:0] VEC [NVEC] = '{
    {8'd40, 8'hA5, 32'hDEADBEEF},
    {8'd40, 8'h00, 32'h00000000},
    {8'd40, 8'hFF, 32'hFFFFFFFF},
    {8'd39, 8'h12, 32'h12345678},
    {8'd40, 8'h3C, 32'h80000001},
    {8'd41, 8'h77, 32'h0F0F0F0F},
    {8'd1,  8'h01, 32'h00000000},
    {8'd40, 8'h81, 32'h55AA33CC}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic        wr_stb;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  int tests = 0, fails = 0;
  logic [7:0]  last_addr = '0;
  logic [31:0] last_data = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_cfg_rx dut_i (.clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda),
                    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data));

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag,
                     input logic [39:0] act, input logic [39:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_start();
    scl = 1'b1; sda = 1'b1; wait_n(2*HALF);
    sda = 1'b0; wait_n(2*HALF);
  endtask

  task automatic send_bit(input logic b);
    scl = 1'b0; sda = b; wait_n(HALF);
    scl = 1'b1; wait_n(HALF);
  endtask

  task automatic send_bits(input logic [39:0] word, input int n);
    for (int i = 0; i < n; i++) send_bit(i < 40 ? word[39-i] : 1'b0);
  endtask

  // closing sequence, then watch the strobe and outputs
  task automatic stop_and_check(input bit expect_wr, input logic [39:0] word,
                                input string tag);
    int hi = 0;
    logic [7:0] ca = wr_addr;
    logic [31:0] cd = wr_data;
    scl = 1'b0; sda = 1'b0; wait_n(HALF);
    scl = 1'b1; wait_n(HALF);
    sda = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (wr_stb) begin hi++; ca = wr_addr; cd = wr_data; end
    end
    chk(hi == (expect_wr ? 1 : 0), {tag, " strobe cycles"}, 40'(hi),
        expect_wr ? 40'd1 : 40'd0);
    if (expect_wr) begin
      chk({ca, cd} == word, {tag, " written addr/data"}, {ca, cd}, word);
      last_addr = word[39:32]; last_data = word[31:0];
    end else begin
      chk({wr_addr, wr_data} == {last_addr, last_data}, {tag, " outputs held"},
          {wr_addr, wr_data}, {last_addr, last_data});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait_n(4);
    // R1: reset values
    chk(wr_stb == 1'b0, "R1 strobe in reset", 40'(wr_stb), 40'd0);
    rst = 1'b0; wait_n(4);
    chk({wr_addr, wr_data} == 40'd0, "R1 outputs after reset",
        {wr_addr, wr_data}, 40'd0);
    chk(wr_stb == 1'b0, "R1 strobe after reset", 40'(wr_stb), 40'd0);

    // R2 R3 R4 R6: table of frames of various lengths and patterns
    for (int v = 0; v < NVEC; v++) begin
      send_start();
      send_bits(VEC[v][39:0], int'(VEC[v][47:40]));
      stop_and_check(VEC[v][47:40] == 8'd40, VEC[v][39:0],
                     $sformatf("R4/R6 vector %0d", v));
    end

    // R8: closing with no frame in progress
    scl = 1'b0; wait_n(HALF); sda = 1'b0; wait_n(HALF);
    stop_and_check(1'b0, 40'd0, "R8 idle stop");

    // R7: restart in the middle of a frame
    send_start();
    send_bits(40'hFF_FFFF_FFFF, 15);
    send_bit(1'b1);
    sda = 1'b0; wait_n(2*HALF);
    send_bits({8'h5E, 32'hC0FFEE11}, 40);
    stop_and_check(1'b1, {8'h5E, 32'hC0FFEE11}, "R7 restart");

    // R8 R1: reset in the middle of a frame, clock line low
    send_start();
    send_bits({8'h42, 32'h13579BDF}, 20);
    scl = 1'b0; wait_n(HALF);
    rst = 1'b1; wait_n(2);
    chk(wr_stb == 1'b0, "R1 strobe during mid-frame reset", 40'(wr_stb), 40'd0);
    rst = 1'b0; wait_n(2);
    last_addr = '0; last_data = '0;
    chk({wr_addr, wr_data} == 40'd0, "R1 outputs cleared by reset",
        {wr_addr, wr_data}, 40'd0);
    send_bits(40'h00_0000_0000, 20);
    stop_and_check(1'b0, 40'd0, "R8 frame cut by reset");

    // R3 R5: a further good frame after the discarded one
    send_start();
    send_bits({8'h01, 32'h00000080}, 40);
    stop_and_check(1'b1, {8'h01, 32'h00000080}, "R3/R5 frame after reset");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule